// File: doc/BRIEF.md
# DMA Channel Register Window Bridge

The bridge gives each of eight DMA channels its own 16-byte I/O register window, placed anywhere in a 16-bit I/O space. An access that lands in a window is answered from local per-channel shadow registers or is turned into one or more transactions on a byte-wide master port. That port faces a legacy pair of cascaded DMA controllers and their page registers. Channels 0-3 belong to the low controller and channels 4-7 to the high one.

Window placement comes from a small configuration port: a channel number, an enable and a 16-bit base. One write replaces both the old placement and the enable. The host side offers one request at a time (`s_valid`/`s_ready`) and gets a one-cycle response pulse carrying a hit flag and read data.

Some window offsets do more than one thing on the master port. The unmask-all offset sends four single-mask writes. The mask-set offset builds a single-mask command from the written data and the channel number. While such a sequence is in flight the host side stays stalled.

Top module: `dma_window_bridge`

## Requirements
- R1: A request hits a channel only when that channel is enabled, its 16-bit base is nonzero, and address bits 15:4 equal base bits 15:4. If several channels match, the lowest-numbered one answers. A miss makes no master traffic and responds with `s_hit`=0 and `s_rdata`=0xFF.
- R2: A configuration write replaces the channel's base and enable in one step. From the next request on, the old window no longer answers and the new one does.
- R3: Writes to offset 0 and offset 1 set the low and high byte of the channel's address. Reads of the same offsets return those bytes.
- R4: Writes to offset 4 and offset 5 set the low and high byte of the channel's count. Reads of the same offsets return those bytes.
- R5: A write to offset 2 stores the page byte and forwards it as a write to page register 0x80+k (channels 0-3) or 0x88+k (channels 4-7). k is 7, 3, 1, 2 for (channel & 3) = 0, 1, 2, 3. A read of offset 2 returns the stored page.
- R6: Writes to offsets 0x8, 0x9, 0xA, 0xB and 0xD are forwarded unchanged to controller register B+offset. B is 0x00 for channels 0-3 and 0xC0 for channels 4-7.
- R7: A write to offset 0xE sends four writes to B+0xA, with data 0, 1, 2 and 3 in that order.
- R8: A write to offset 0xF sends one write to B+0xA with data {wdata[5:0], channel[1:0]}.
- R9: A read of offset 9 performs a master read (`m_we`=0) of B+0x8 and returns the byte accepted with it.
- R10: Writes to offsets 3, 6, 7 and 0xC change no state and make no master traffic. Reads of any offset other than 0, 1, 2, 4, 5 and 9 return 0xFF. Every write response carries 0xFF.
- R11: A request served locally responds in the cycle after it is accepted. A forwarded request responds in the cycle after its last master handshake. `s_ready` is low from acceptance until that handshake. A stalled master beat holds its address, data and direction.
- R12: After reset every channel is disabled with base 0 and cleared shadows. `s_ready` is 1, and `m_valid` and `resp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel being configured |
| cfg_en | input | 1 | Window enable for that channel |
| cfg_base | input | 16 | Window base for that channel |
| s_valid | input | 1 | Host request valid |
| s_ready | output | 1 | Host request accepted when high together with s_valid |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 16 | Host I/O address |
| s_wdata | input | 8 | Host write data |
| resp_valid | output | 1 | One-cycle response pulse |
| s_hit | output | 1 | Response hit a window |
| s_rdata | output | 8 | Response data |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Master beat accepted |
| m_we | output | 1 | Master beat direction, 1 = write |
| m_addr | output | 8 | Controller or page register address |
| m_wdata | output | 8 | Master write data |
| m_rdata | input | 8 | Master read data, taken on the read handshake |

## Verification
A local read or write response is due exactly one cycle after the request is accepted. The first master beat of a forwarded request also appears one cycle after acceptance. Each further beat follows its predecessor's handshake by one cycle, and the response comes one cycle after the final handshake. The bench drives `m_ready` with an irregular stall pattern so that these delays vary. Its reference model moves by the same edge-by-edge rule: at each falling edge it compares the ports with its queue of expected beats and its expected response, and only then applies the next inputs. Offset 9 reads return the `m_rdata` that was presented in the handshake cycle, which the model captures in that same step.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

    localparam int DATA_W  = 8;
    localparam int MADDR_W = 8;

    localparam logic [3:0] OFS_ADDR_LO  = 4'h0;
    localparam logic [3:0] OFS_ADDR_HI  = 4'h1;
    localparam logic [3:0] OFS_PAGE     = 4'h2;
    localparam logic [3:0] OFS_CNT_LO   = 4'h4;
    localparam logic [3:0] OFS_CNT_HI   = 4'h5;
    localparam logic [3:0] OFS_CMD      = 4'h8;
    localparam logic [3:0] OFS_REQ      = 4'h9;
    localparam logic [3:0] OFS_MASK1    = 4'hA;
    localparam logic [3:0] OFS_MODE     = 4'hB;
    localparam logic [3:0] OFS_CLEAR    = 4'hD;
    localparam logic [3:0] OFS_UNMASK4  = 4'hE;
    localparam logic [3:0] OFS_MASKSET  = 4'hF;

    localparam logic [MADDR_W-1:0] PAGE_LO_BASE = 8'h80;
    localparam logic [MADDR_W-1:0] PAGE_HI_BASE = 8'h88;

    typedef enum logic [1:0] {
        SEQ_WR1 = 2'd0,
        SEQ_WR4 = 2'd1,
        SEQ_RD  = 2'd2
    } seq_kind_e;

    typedef struct packed {
        logic [15:0]       addr;
        logic [15:0]       cnt;
        logic [DATA_W-1:0] page;
    } chan_shadow_t;

    function automatic logic [MADDR_W-1:0] page_index(input logic [1:0] sub);
        case (sub)
            2'd0:    return 8'd7;
            2'd1:    return 8'd3;
            2'd2:    return 8'd1;
            default: return 8'd2;
        endcase
    endfunction

    function automatic logic [MADDR_W-1:0] ctrl_base(input logic upper);
        return upper ? 8'hC0 : 8'h00;
    endfunction

endpackage

// File: rtl/dwb_window_decode.sv
module dwb_window_decode #(
    parameter int NUM_CH = 8,
    parameter int AW     = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]         win_en,
    input  logic [NUM_CH-1:0][AW-1:0] win_base,
    input  logic [AW-1:0]             addr,
    output logic                      hit,
    output logic [CH_W-1:0]           ch
);
    logic [NUM_CH-1:0] match;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
        assign match[g] = win_en[g] && (win_base[g] != '0)
                          && (addr[AW-1:4] == win_base[g][AW-1:4]);
    end

    always_comb begin
        hit = |match;
        ch  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (match[i]) ch = CH_W'(i);
        end
    end
endmodule

// File: rtl/dwb_channel_regs.sv
module dwb_channel_regs
    import dwb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int AW     = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [CH_W-1:0]           cfg_ch,
    input  logic                      cfg_en,
    input  logic [AW-1:0]             cfg_base,
    input  logic                      sh_we,
    input  logic [CH_W-1:0]           sh_ch,
    input  logic [3:0]                sh_ofs,
    input  logic [DATA_W-1:0]         sh_data,
    output logic [NUM_CH-1:0]         win_en,
    output logic [NUM_CH-1:0][AW-1:0] win_base,
    input  logic [CH_W-1:0]           rd_ch,
    output chan_shadow_t              rd_shadow
);
    chan_shadow_t sh_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                win_en[g]   <= 1'b0;
                win_base[g] <= '0;
                sh_q[g]     <= '0;
            end else begin
                if (cfg_we && cfg_ch == CH_W'(g)) begin
                    win_en[g]   <= cfg_en;
                    win_base[g] <= cfg_base;
                end
                if (sh_we && sh_ch == CH_W'(g)) begin
                    case (sh_ofs)
                        OFS_ADDR_LO: sh_q[g].addr[7:0]  <= sh_data;
                        OFS_ADDR_HI: sh_q[g].addr[15:8] <= sh_data;
                        OFS_PAGE:    sh_q[g].page       <= sh_data;
                        OFS_CNT_LO:  sh_q[g].cnt[7:0]   <= sh_data;
                        OFS_CNT_HI:  sh_q[g].cnt[15:8]  <= sh_data;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign rd_shadow = sh_q[rd_ch];
endmodule

// File: rtl/dwb_fwd_seq.sv
module dwb_fwd_seq
    import dwb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  seq_kind_e          kind,
    input  logic [MADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  data,
    output logic               busy,
    output logic               done,
    output logic               m_valid,
    input  logic               m_ready,
    output logic               m_we,
    output logic [MADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0]  m_wdata
);
    seq_kind_e          kind_q;
    logic [MADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]  data_q;
    logic [1:0]         beat_q;
    logic               last;

    assign last    = (kind_q != SEQ_WR4) || (beat_q == 2'd3);
    assign m_valid = busy;
    assign m_we    = (kind_q != SEQ_RD);
    assign m_addr  = addr_q;
    assign m_wdata = (kind_q == SEQ_WR4) ? {6'b0, beat_q} : data_q;
    assign done    = busy && m_ready && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            kind_q <= SEQ_WR1;
            addr_q <= '0;
            data_q <= '0;
            beat_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                kind_q <= kind;
                addr_q <= addr;
                data_q <= data;
                beat_q <= '0;
            end
        end else if (m_ready) begin
            if (last) busy <= 1'b0;
            else      beat_q <= beat_q + 2'd1;
        end
    end
endmodule

// File: rtl/dma_window_bridge.sv
module dma_window_bridge
    import dwb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int AW     = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CH_W-1:0]    cfg_ch,
    input  logic               cfg_en,
    input  logic [AW-1:0]      cfg_base,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic               s_write,
    input  logic [AW-1:0]      s_addr,
    input  logic [DATA_W-1:0]  s_wdata,
    output logic               resp_valid,
    output logic               s_hit,
    output logic [DATA_W-1:0]  s_rdata,
    output logic               m_valid,
    input  logic               m_ready,
    output logic               m_we,
    output logic [MADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0]  m_wdata,
    input  logic [DATA_W-1:0]  m_rdata
);
    logic [NUM_CH-1:0]         win_en;
    logic [NUM_CH-1:0][AW-1:0] win_base;
    logic                      dec_hit;
    logic [CH_W-1:0]           dec_ch;
    chan_shadow_t              shadow;
    logic [3:0]                ofs;
    logic                      upper;
    logic [MADDR_W-1:0]        cb;
    logic                      accept;
    logic                      seq_busy;
    logic                      seq_done;
    logic                      is_fwd;
    seq_kind_e                 fkind;
    logic [MADDR_W-1:0]        faddr;
    logic [DATA_W-1:0]         fdata;
    logic [DATA_W-1:0]         local_rd;
    logic                      pend_read;

    assign ofs     = s_addr[3:0];
    assign s_ready = !seq_busy;
    assign accept  = s_valid && s_ready;
    assign upper   = (int'(dec_ch) >= NUM_CH / 2);
    assign cb      = ctrl_base(upper);

    dwb_window_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_decode (
        .win_en   (win_en),
        .win_base (win_base),
        .addr     (s_addr),
        .hit      (dec_hit),
        .ch       (dec_ch)
    );

    dwb_channel_regs #(.NUM_CH(NUM_CH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_en    (cfg_en),
        .cfg_base  (cfg_base),
        .sh_we     (accept && dec_hit && s_write),
        .sh_ch     (dec_ch),
        .sh_ofs    (ofs),
        .sh_data   (s_wdata),
        .win_en    (win_en),
        .win_base  (win_base),
        .rd_ch     (dec_ch),
        .rd_shadow (shadow)
    );

    always_comb begin
        is_fwd   = 1'b0;
        fkind    = SEQ_WR1;
        faddr    = cb + {4'h0, ofs};
        fdata    = s_wdata;
        local_rd = 8'hFF;
        if (s_write) begin
            case (ofs)
                OFS_PAGE: begin
                    is_fwd = 1'b1;
                    faddr  = (upper ? PAGE_HI_BASE : PAGE_LO_BASE) + page_index(dec_ch[1:0]);
                end
                OFS_CMD, OFS_REQ, OFS_MASK1, OFS_MODE, OFS_CLEAR: is_fwd = 1'b1;
                OFS_UNMASK4: begin
                    is_fwd = 1'b1;
                    fkind  = SEQ_WR4;
                    faddr  = cb + {4'h0, OFS_MASK1};
                end
                OFS_MASKSET: begin
                    is_fwd = 1'b1;
                    faddr  = cb + {4'h0, OFS_MASK1};
                    fdata  = {s_wdata[5:0], dec_ch[1:0]};
                end
                default: ;
            endcase
        end else begin
            case (ofs)
                OFS_ADDR_LO: local_rd = shadow.addr[7:0];
                OFS_ADDR_HI: local_rd = shadow.addr[15:8];
                OFS_PAGE:    local_rd = shadow.page;
                OFS_CNT_LO:  local_rd = shadow.cnt[7:0];
                OFS_CNT_HI:  local_rd = shadow.cnt[15:8];
                OFS_REQ: begin
                    is_fwd = 1'b1;
                    fkind  = SEQ_RD;
                    faddr  = cb + {4'h0, OFS_CMD};
                end
                default: ;
            endcase
        end
    end

    dwb_fwd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept && dec_hit && is_fwd),
        .kind    (fkind),
        .addr    (faddr),
        .data    (fdata),
        .busy    (seq_busy),
        .done    (seq_done),
        .m_valid (m_valid),
        .m_ready (m_ready),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_wdata (m_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            s_hit      <= 1'b0;
            s_rdata    <= 8'hFF;
            pend_read  <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            if (accept) begin
                s_hit     <= dec_hit;
                pend_read <= !s_write;
                if (!(dec_hit && is_fwd)) begin
                    resp_valid <= 1'b1;
                    s_rdata    <= (dec_hit && !s_write) ? local_rd : 8'hFF;
                end
            end
            if (seq_done) begin
                resp_valid <= 1'b1;
                s_rdata    <= pend_read ? m_rdata : 8'hFF;
            end
        end
    end
endmodule

// File: rtl/dwb_checker.sv
module dwb_checker (
    input logic       clk,
    input logic       rst,
    input logic       s_ready,
    input logic       resp_valid,
    input logic       s_hit,
    input logic [7:0] s_rdata,
    input logic       m_valid,
    input logic       m_ready,
    input logic       m_we,
    input logic [7:0] m_addr,
    input logic [7:0] m_wdata
);
    a_r11_busy_blocks_host: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> !s_ready);

    a_r11_resp_or_next_beat: assert property (@(posedge clk) disable iff (rst)
        (m_valid && m_ready) |=> (m_valid || resp_valid));

    a_r11_beat_held: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_wdata) && $stable(m_we)));

    a_r11_resp_not_busy: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !m_valid);

    a_r1_miss_data: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !s_hit) |-> (s_rdata == 8'hFF));

    a_r6_target_range: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> (m_addr[7:4] == 4'h0 || m_addr[7:4] == 4'h8 || m_addr[7:4] == 4'hC));

    a_r9_read_target: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_we) |-> (m_addr[3:0] == 4'h8));

    a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (s_ready && !m_valid && !resp_valid));
endmodule

bind dma_window_bridge dwb_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .s_ready    (s_ready),
    .resp_valid (resp_valid),
    .s_hit      (s_hit),
    .s_rdata    (s_rdata),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .m_we       (m_we),
    .m_addr     (m_addr),
    .m_wdata    (m_wdata)
);

// File: tb/dma_window_bridge_tb_top.sv
module dma_window_bridge_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_en = 1'b0;
    logic [2:0]  cfg_ch = '0;
    logic [15:0] cfg_base = '0;
    logic        s_valid = 1'b0, s_write = 1'b0;
    logic [15:0] s_addr = '0;
    logic [7:0]  s_wdata = '0;
    logic        s_ready, resp_valid, s_hit;
    logic [7:0]  s_rdata;
    logic        m_valid, m_we;
    logic        m_ready = 1'b0;
    logic [7:0]  m_addr, m_wdata;
    logic [7:0]  m_rdata = '0;

    dma_window_bridge dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
        .resp_valid(resp_valid), .s_hit(s_hit), .s_rdata(s_rdata),
        .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        bit       we;
        bit [7:0] a;
        bit [7:0] d;
        string    tag;
    } beat_t;

    bit        md_en   [8];
    bit [15:0] md_base [8];
    bit [15:0] md_addr [8];
    bit [15:0] md_cnt  [8];
    bit [7:0]  md_page [8];
    beat_t     q[$];
    bit        exp_resp, exp_hit, pend_read;
    bit [7:0]  exp_rdata;
    string     resp_tag, pend_tag, cur_tag;
    int        cyc, n_chk, n_fail;
    bit        acc;

    bit        st_valid, st_write, st_cfg_we, st_cfg_en;
    bit [15:0] st_addr, st_cfg_base;
    bit [7:0]  st_wdata;
    bit [2:0]  st_cfg_ch;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    function automatic int find_ch(input bit [15:0] a);
        for (int c = 0; c < 8; c++)
            if (md_en[c] && md_base[c] != 16'h0 && a[15:4] == md_base[c][15:4]) return c;
        return -1;
    endfunction

    function automatic bit [7:0] page_k(input int c);
        case (c % 4)
            0: return 8'd7;
            1: return 8'd3;
            2: return 8'd1;
            default: return 8'd2;
        endcase
    endfunction

    function automatic void push(input bit we, input bit [7:0] a, input bit [7:0] d);
        beat_t b;
        b.we = we; b.a = a; b.d = d; b.tag = cur_tag;
        q.push_back(b);
    endfunction

    task automatic tick();
        bit       rnext;
        int       c;
        bit [3:0] o;
        bit [7:0] cbv;
        beat_t    b;
        @(negedge clk);
        cyc++;
        chk(s_ready == (q.size() == 0), "R11", "s_ready", s_ready, q.size() == 0);
        chk(m_valid == (q.size() != 0), "R11", "m_valid", m_valid, q.size() != 0);
        if (q.size() != 0) begin
            chk(m_we == q[0].we, q[0].tag, "m_we", m_we, q[0].we);
            chk(m_addr == q[0].a, q[0].tag, "m_addr", m_addr, q[0].a);
            if (q[0].we) chk(m_wdata == q[0].d, q[0].tag, "m_wdata", m_wdata, q[0].d);
        end
        chk(resp_valid == exp_resp, "R11", "resp_valid", resp_valid, exp_resp);
        if (exp_resp) begin
            chk(s_hit == exp_hit, resp_tag, "s_hit", s_hit, exp_hit);
            chk(s_rdata == exp_rdata, resp_tag, "s_rdata", s_rdata, exp_rdata);
        end
        s_valid  = st_valid; s_write = st_write; s_addr = st_addr; s_wdata = st_wdata;
        cfg_we   = st_cfg_we; cfg_ch = st_cfg_ch; cfg_en = st_cfg_en; cfg_base = st_cfg_base;
        m_ready  = ((cyc % 5) != 2) && ((cyc % 7) != 4);
        m_rdata  = 8'(cyc * 7 + 3);
        rnext = 1'b0;
        acc   = 1'b0;
        if (q.size() != 0) begin
            if (m_ready) begin
                b = q.pop_front();
                if (q.size() == 0) begin
                    rnext     = 1'b1;
                    exp_hit   = 1'b1;
                    exp_rdata = pend_read ? m_rdata : 8'hFF;
                    resp_tag  = pend_tag;
                end
            end
        end else if (st_valid) begin
            acc = 1'b1;
            c   = find_ch(st_addr);
            o   = st_addr[3:0];
            pend_read = !st_write;
            pend_tag  = cur_tag;
            if (c < 0) begin
                rnext = 1'b1; exp_hit = 1'b0; exp_rdata = 8'hFF; resp_tag = cur_tag;
            end else begin
                cbv = (c >= 4) ? 8'hC0 : 8'h00;
                exp_hit = 1'b1; exp_rdata = 8'hFF; resp_tag = cur_tag;
                if (st_write) begin
                    case (o)
                        4'h0: md_addr[c][7:0]  = st_wdata;
                        4'h1: md_addr[c][15:8] = st_wdata;
                        4'h4: md_cnt[c][7:0]   = st_wdata;
                        4'h5: md_cnt[c][15:8]  = st_wdata;
                        4'h2: begin
                            md_page[c] = st_wdata;
                            push(1, ((c >= 4) ? 8'h88 : 8'h80) + page_k(c), st_wdata);
                        end
                        4'h8, 4'h9, 4'hA, 4'hB, 4'hD: push(1, cbv + 8'(o), st_wdata);
                        4'hE: for (int k = 0; k < 4; k++) push(1, cbv + 8'hA, 8'(k));
                        4'hF: push(1, cbv + 8'hA, 8'((st_wdata << 2) | (c & 3)));
                        default: ;
                    endcase
                end else begin
                    case (o)
                        4'h0: exp_rdata = md_addr[c][7:0];
                        4'h1: exp_rdata = md_addr[c][15:8];
                        4'h2: exp_rdata = md_page[c];
                        4'h4: exp_rdata = md_cnt[c][7:0];
                        4'h5: exp_rdata = md_cnt[c][15:8];
                        4'h9: push(0, cbv + 8'h8, 8'h00);
                        default: ;
                    endcase
                end
                if (q.size() == 0) rnext = 1'b1;
            end
        end
        if (st_cfg_we) begin
            md_en[st_cfg_ch]   = st_cfg_en;
            md_base[st_cfg_ch] = st_cfg_base;
        end
        exp_resp = rnext;
    endtask

    task automatic access(input bit w, input bit [15:0] a, input bit [7:0] d, input string tag);
        cur_tag = tag; st_valid = 1; st_write = w; st_addr = a; st_wdata = d;
        do tick(); while (!acc);
        st_valid = 0;
    endtask

    task automatic drain();
        while (q.size() != 0 || exp_resp) tick();
    endtask

    task automatic op(input bit w, input bit [15:0] a, input bit [7:0] d, input string tag);
        access(w, a, d, tag);
        drain();
    endtask

    task automatic cfg(input int c, input bit en, input bit [15:0] base);
        st_cfg_we = 1; st_cfg_ch = 3'(c); st_cfg_en = en; st_cfg_base = base;
        tick();
        st_cfg_we = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: idle state right after reset
        chk(s_ready == 1'b1, "R12", "s_ready", s_ready, 1);
        chk(m_valid == 1'b0, "R12", "m_valid", m_valid, 0);
        chk(resp_valid == 1'b0, "R12", "resp_valid", resp_valid, 0);
        op(0, 16'h0000, 0, "R12");
        op(0, 16'h0002, 0, "R12");
        // R1: disabled and zero-base windows miss
        cfg(0, 0, 16'h1000);
        op(0, 16'h1000, 0, "R1");
        cfg(0, 1, 16'h1000);
        cfg(5, 1, 16'h2040);
        cfg(3, 1, 16'h0000);
        cfg(7, 1, 16'h3470);
        op(0, 16'h0004, 0, "R1");
        // R3 / R4: address and count shadows
        op(1, 16'h1000, 8'h34, "R3");
        op(1, 16'h1001, 8'h12, "R3");
        op(0, 16'h1000, 0, "R3");
        op(0, 16'h1001, 0, "R3");
        op(1, 16'h2044, 8'hCD, "R4");
        op(1, 16'h2045, 8'hAB, "R4");
        op(0, 16'h2044, 0, "R4");
        op(0, 16'h2045, 0, "R4");
        // R5: page forwarding and readback
        op(1, 16'h1002, 8'h9A, "R5");
        op(0, 16'h1002, 0, "R5");
        op(1, 16'h2042, 8'h44, "R5");
        op(1, 16'h3472, 8'h71, "R5");
        op(0, 16'h3472, 0, "R5");
        // R6: control forwarding, both controllers
        foreach (q[i]) begin end
        for (int k = 0; k < 5; k++) begin
            bit [3:0] o;
            o = (k == 4) ? 4'hD : 4'(8 + k);
            op(1, 16'h1000 | 16'(o), 8'(16 + k), "R6");
            op(1, 16'h2040 | 16'(o), 8'(32 + k), "R6");
        end
        // R7 / R8: mask shortcuts
        op(1, 16'h204E, 8'h00, "R7");
        op(1, 16'h100E, 8'h55, "R7");
        op(1, 16'h204F, 8'h41, "R8");
        op(1, 16'h100F, 8'h03, "R8");
        op(1, 16'h347F, 8'hFF, "R8");
        // R9: status read through the master port
        op(0, 16'h1009, 0, "R9");
        op(0, 16'h2049, 0, "R9");
        // R10: unlisted offsets
        op(1, 16'h1003, 8'hEE, "R10");
        op(1, 16'h1006, 8'hEE, "R10");
        op(1, 16'h1007, 8'hEE, "R10");
        op(1, 16'h100C, 8'hEE, "R10");
        op(0, 16'h1003, 0, "R10");
        op(0, 16'h1008, 0, "R10");
        op(0, 16'h100C, 0, "R10");
        op(0, 16'h100F, 0, "R10");
        op(0, 16'h1000, 0, "R10");
        op(0, 16'h1002, 0, "R10");
        // R1: overlap, lowest channel answers
        cfg(2, 1, 16'h100A);
        op(0, 16'h1002, 0, "R1");
        // R2: relocation and disable
        cfg(0, 1, 16'h3000);
        op(0, 16'h1002, 0, "R2");
        op(0, 16'h3002, 0, "R2");
        op(0, 16'h3000, 0, "R2");
        cfg(5, 0, 16'h2040);
        op(0, 16'h2044, 0, "R2");
        op(1, 16'h2042, 8'h11, "R2");
        // R11: back-to-back requests without idle cycles
        access(1, 16'h300E, 8'h00, "R11");
        access(0, 16'h3000, 0, "R11");
        access(1, 16'h3009, 8'h77, "R11");
        access(0, 16'h3009, 0, "R11");
        access(1, 16'h3001, 8'h5E, "R11");
        access(0, 16'h3001, 0, "R11");
        drain();
        repeat (3) tick();
        finish_run();
    end
endmodule